// File: doc/BRIEF.md
# NAND Flash Command Interface Model

This block is a synthesizable device-side model of a byte-wide NAND flash command interface, intended as a target for host controller verification. Host strobes (command latch, address latch, write strobe, read strobe, chip select) are sampled with a fast system clock. The model decodes command bytes, collects five address bytes, loads or fills a one-page buffer, and returns buffer bytes or a status byte on read strobes. A small on-model array of a few pages serves as storage. Read transfers and program operations hold the busy pin low for a parameterised number of clocks while the array is copied byte by byte.

The model also checks the rules a host must obey. A confirm with nothing loaded is dropped. While busy, only the status and reset commands are accepted. Each page tolerates a limited number of partial programs, and a further attempt is refused and flagged.

Top module: `nand_cmd_model`

## Requirements
- R1: Command 00h, five address bytes, then 30h copies the page selected by address byte 2 (low bits) into the page buffer, with rb_n held low for exactly READ_CYCLES clocks. The column comes from the low bits of address byte 0.
- R2: Each falling read strobe outside status mode returns the buffer byte at the column pointer and advances the pointer. At the last column the pointer stays put, so the last byte repeats.
- R3: Command 80h fills the page buffer with FFh and takes five address bytes. Data bytes (CLE and ALE both low) are then written at the column, which advances. Command 85h followed by address bytes moves the column without changing the page.
- R4: A 10h with no data byte loaded since 80h, or outside a load sequence, starts nothing. rb_n stays high and the array is unchanged.
- R5: Programming takes PROG_CYCLES clocks with rb_n low. Each loaded byte becomes old AND new. Status bit 0 (fail) is set when a loaded byte asks for a 1 where the cell already holds 0.
- R6: Status bit 6 is 1 when ready and 0 when busy. While busy, every command except 70h and FFh is ignored, and so are address and data bytes.
- R7: After 70h, each read strobe returns the status byte until another accepted command other than 70h arrives.
- R8: Each page accepts at most NOP_MAX programs. A further confirm on that page is refused without going busy or touching the array, and it sets status bits 1 (violation) and 0.
- R9: Commands latch on the rising write strobe with CLE high and ALE low, addresses with ALE high and CLE low, and data with both low. With ce_n high, all strobes are ignored and io_oe is 0. io_oe is 1 while ce_n and re_n are both low.
- R10: FFh is accepted at any time. It ends busy at once (rb_n high on the next clock), sets the column to 0, leaves status mode, clears status bits 1 and 0, and keeps the buffer contents.
- R11: Status bit 7 equals wp_n. A confirm while wp_n is low sets the fail bit, does not go busy, and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, latches on rising edge |
| re_n | input | 1 | Read strobe, advances on falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte from host |
| io_out | output | 8 | Byte to host |
| io_oe | output | 1 | Output enable for io_out |
| rb_n | output | 1 | Ready (1) / busy (0) |

## Verification
The bench keeps its own copy of every page and sweeps read-back of all pages from column 0, plus a run past the last column. A model that wraps or stops early returns a wrong byte there. It programs over an already cleared byte to provoke the fail bit, which a model ORing new data, or checking unloaded bytes, would misreport. It then exercises the ninth partial program, a lone confirm, a load command issued mid-busy, an abort during programming, write protect, and strobes with chip select high. A model that accepts any of these wrongly shows a busy period, a changed byte or a wrong status value where the bench expects none.

// File: rtl/nand_model_pkg.sv
package nand_model_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_SET = 2'd1,
        ST_PG_SET = 2'd2,
        ST_BUSY   = 2'd3
    } mode_e;

    localparam logic [7:0] CMD_READ    = 8'h00;
    localparam logic [7:0] CMD_READ_GO = 8'h30;
    localparam logic [7:0] CMD_LOAD    = 8'h80;
    localparam logic [7:0] CMD_MOVE    = 8'h85;
    localparam logic [7:0] CMD_PROG    = 8'h10;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_RESET   = 8'hFF;
endpackage

// File: rtl/nand_pin_edge.sv
module nand_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin;
    end

    assign rise = en & ~prev_q & pin;
    assign fall = en & prev_q & ~pin;
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
    parameter int PAGES = 4,
    parameter int COLS  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(PAGES)-1:0] page,
    input  logic [$clog2(COLS)-1:0]  col,
    input  logic                     wr_en,
    input  logic [7:0]               wr_data,
    output logic [7:0]               rd_data
);
    logic [7:0] mem_q [PAGES][COLS];

    assign rd_data = mem_q[page][col];

    // programming can only clear bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++)
                for (int c = 0; c < COLS; c++)
                    mem_q[p][c] <= 8'hFF;
        end else if (wr_en) begin
            mem_q[page][col] <= mem_q[page][col] & wr_data;
        end
    end
endmodule

// File: rtl/nand_cmd_model.sv
module nand_cmd_model
    import nand_model_pkg::*;
#(
    parameter int PAGES       = 4,
    parameter int COLS        = 16,
    parameter int READ_CYCLES = 40,
    parameter int PROG_CYCLES = 60,
    parameter int NOP_MAX     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       rb_n
);
    localparam int CW  = $clog2(COLS);
    localparam int PW  = $clog2(PAGES);
    localparam int IW  = CW + 1;
    localparam int MAXC = (READ_CYCLES > PROG_CYCLES) ? READ_CYCLES : PROG_CYCLES;
    localparam int BW  = $clog2(MAXC + 1);
    localparam int NW  = $clog2(NOP_MAX + 1);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    typedef struct packed {
        mode_e                       mode;
        logic                        op_pg;
        logic [BW-1:0]               bcnt;
        logic [IW-1:0]               idx;
        logic [CW-1:0]               col;
        logic [PW-1:0]               page;
        logic [2:0]                  acnt;
        logic                        col_only;
        logic                        loaded;
        logic [COLS-1:0]             mask;
        logic [COLS-1:0][7:0]        preg;
        logic                        stat;
        logic                        fail;
        logic                        viol;
        logic [PAGES-1:0][NW-1:0]    nop;
        logic [7:0]                  dout;
    } state_t;

    state_t st_d, st_q;
    logic   we_rise, we_fall, re_rise, re_fall;
    logic   wr_en, busy;
    logic [7:0] rd_data, stat_byte;

    nand_pin_edge u_we (.clk(clk), .rst_n(rst_n), .en(~ce_n), .pin(we_n),
                        .rise(we_rise), .fall(we_fall));
    nand_pin_edge u_re (.clk(clk), .rst_n(rst_n), .en(~ce_n), .pin(re_n),
                        .rise(re_rise), .fall(re_fall));

    nand_page_store #(.PAGES(PAGES), .COLS(COLS)) u_store (
        .clk(clk), .rst_n(rst_n), .page(st_q.page), .col(st_q.idx[CW-1:0]),
        .wr_en(wr_en), .wr_data(st_q.preg[st_q.idx[CW-1:0]]), .rd_data(rd_data)
    );

    assign busy      = (st_q.mode == ST_BUSY);
    assign stat_byte = {wp_n, ~busy, 4'b0000, st_q.viol, st_q.fail};

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;

        // array transfer, one byte per clock while busy
        if (busy) begin
            if (st_q.idx < IW'(COLS)) begin
                if (st_q.op_pg) begin
                    if (st_q.mask[st_q.idx[CW-1:0]]) begin
                        wr_en = 1'b1;
                        if ((rd_data & st_q.preg[st_q.idx[CW-1:0]]) != st_q.preg[st_q.idx[CW-1:0]])
                            st_d.fail = 1'b1;
                    end
                end else begin
                    st_d.preg[st_q.idx[CW-1:0]] = rd_data;
                end
                st_d.idx = st_q.idx + IW'(1);
            end
            if (st_q.bcnt == '0) st_d.mode = ST_IDLE;
            else                 st_d.bcnt = st_q.bcnt - BW'(1);
        end

        // read strobe
        if (re_fall) begin
            if (st_q.stat) begin
                st_d.dout = stat_byte;
            end else if (!busy) begin
                st_d.dout = st_q.preg[st_q.col];
                if (st_q.col != LAST_COL) st_d.col = st_q.col + CW'(1);
            end
        end

        // write strobe
        if (we_rise) begin
            if (cle && !ale) begin
                if (io_in == CMD_STATUS) begin
                    st_d.stat = 1'b1;
                end else if (io_in == CMD_RESET) begin
                    st_d.mode = ST_IDLE;
                    st_d.col  = '0;
                    st_d.acnt = '0;
                    st_d.stat = 1'b0;
                    st_d.fail = 1'b0;
                    st_d.viol = 1'b0;
                end else if (!busy) begin
                    case (io_in)
                        CMD_READ: begin
                            st_d.mode     = ST_RD_SET;
                            st_d.acnt     = '0;
                            st_d.col_only = 1'b0;
                            st_d.stat     = 1'b0;
                        end
                        CMD_READ_GO: begin
                            if (st_q.mode == ST_RD_SET && st_q.acnt == 3'd5) begin
                                st_d.mode  = ST_BUSY;
                                st_d.op_pg = 1'b0;
                                st_d.bcnt  = BW'(READ_CYCLES - 1);
                                st_d.idx   = '0;
                                st_d.stat  = 1'b0;
                            end
                        end
                        CMD_LOAD: begin
                            st_d.mode     = ST_PG_SET;
                            st_d.acnt     = '0;
                            st_d.col_only = 1'b0;
                            st_d.loaded   = 1'b0;
                            st_d.mask     = '0;
                            st_d.preg     = '1;
                            st_d.stat     = 1'b0;
                        end
                        CMD_MOVE: begin
                            if (st_q.mode == ST_PG_SET) begin
                                st_d.acnt     = '0;
                                st_d.col_only = 1'b1;
                                st_d.stat     = 1'b0;
                            end
                        end
                        CMD_PROG: begin
                            if (st_q.mode == ST_PG_SET && st_q.loaded) begin
                                st_d.stat = 1'b0;
                                st_d.fail = 1'b0;
                                st_d.viol = 1'b0;
                                if (!wp_n) begin
                                    st_d.fail = 1'b1;
                                    st_d.mode = ST_IDLE;
                                end else if (st_q.nop[st_q.page] == NW'(NOP_MAX)) begin
                                    st_d.fail = 1'b1;
                                    st_d.viol = 1'b1;
                                    st_d.mode = ST_IDLE;
                                end else begin
                                    st_d.nop[st_q.page] = st_q.nop[st_q.page] + NW'(1);
                                    st_d.mode  = ST_BUSY;
                                    st_d.op_pg = 1'b1;
                                    st_d.bcnt  = BW'(PROG_CYCLES - 1);
                                    st_d.idx   = '0;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end else if (ale && !cle) begin
                if ((st_q.mode == ST_RD_SET || st_q.mode == ST_PG_SET) && st_q.acnt != 3'd5) begin
                    if (st_q.acnt == 3'd0) st_d.col = io_in[CW-1:0];
                    if (st_q.acnt == 3'd2 && !st_q.col_only) st_d.page = io_in[PW-1:0];
                    st_d.acnt = st_q.acnt + 3'd1;
                end
            end else if (!cle && !ale) begin
                if (st_q.mode == ST_PG_SET) begin
                    st_d.preg[st_q.col] = io_in;
                    st_d.mask[st_q.col] = 1'b1;
                    st_d.loaded         = 1'b1;
                    if (st_q.col != LAST_COL) st_d.col = st_q.col + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= ST_IDLE;
            st_q.preg <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_out = st_q.dout;
    assign io_oe  = ~ce_n & ~re_n;
    assign rb_n   = ~busy;
endmodule

// File: rtl/nand_cmd_chk.sv
module nand_cmd_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cle,
    input logic          wp_n,
    input logic [7:0]    io_in,
    input logic [7:0]    io_out,
    input logic          rb_n,
    input logic          we_rise,
    input logic          re_fall,
    input logic          stat_mode,
    input logic [CW-1:0] col,
    input logic          viol
);
    localparam logic [CW-1:0] LAST = '1;

    // R1: busy only begins right after a read-go or confirm command
    assert_busy_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_n) |-> $past(we_rise && cle && (io_in == 8'h30 || io_in == 8'h10)));

    // R2: read strobe advances the column
    assert_col_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (re_fall && rb_n && !stat_mode && !we_rise && col != LAST) |=> col == $past(col) + CW'(1));

    // R2: column holds at the end
    assert_col_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (re_fall && rb_n && !stat_mode && !we_rise && col == LAST) |=> col == LAST);

    // R6: status ready bit follows rb_n
    assert_status_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (re_fall && stat_mode) |=> io_out[6] == $past(rb_n));

    // R11: status protect bit follows wp_n
    assert_status_wp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (re_fall && stat_mode) |=> io_out[7] == $past(wp_n));

    // R8: violation flag only raised by a confirm
    assert_viol_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> $past(we_rise && cle && io_in == 8'h10));

    // R10: reset command ends busy and rewinds the column
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rise && cle && io_in == 8'hFF) |=> (rb_n && col == '0));
endmodule

bind nand_cmd_model nand_cmd_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cle(cle), .wp_n(wp_n), .io_in(io_in),
    .io_out(io_out), .rb_n(rb_n), .we_rise(we_rise), .re_fall(re_fall),
    .stat_mode(st_q.stat), .col(st_q.col), .viol(st_q.viol)
);

// File: tb/sim_nand_cmd_model.sv
module sim_nand_cmd_model;
    localparam int PAGES = 4;
    localparam int COLS  = 16;
    localparam int RDC   = 40;
    localparam int PGC   = 60;
    localparam int NOPM  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, rb_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] mdl [PAGES][COLS];
    logic [7:0] v;
    logic       oe_seen;
    int         n;

    always #5 clk = ~clk;

    nand_cmd_model #(.PAGES(PAGES), .COLS(COLS), .READ_CYCLES(RDC),
                     .PROG_CYCLES(PGC), .NOP_MAX(NOPM)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk); cle = c; ale = a; io_in = b; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0; ale = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b);  strobe(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b);  strobe(1'b0, 1'b1, b); endtask
    task automatic dat(input logic [7:0] b);  strobe(1'b0, 1'b0, b); endtask

    task automatic addr5(input int col, input int page);
        adr(8'(col)); adr(8'h00); adr(8'(page)); adr(8'h00); adr(8'h00);
    endtask

    // issue a command that may start busy, and count busy clocks
    task automatic go(input logic [7:0] b, output int cnt);
        @(negedge clk); cle = 1'b1; ale = 1'b0; io_in = b; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1;
        cnt = 0;
        @(negedge clk); cle = 1'b0;
        while (!rb_n && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk); re_n = 1'b0;
        @(negedge clk);
        @(negedge clk); b = io_out; oe_seen = io_oe; re_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready();
        int t = 0;
        while (!rb_n && t < 1000) begin t++; @(negedge clk); end
    endtask

    task automatic status(output logic [7:0] b);
        cmd(8'h70); rd(b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < PAGES; p++)
            for (int c = 0; c < COLS; c++)
                mdl[p][c] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R6 reset rb_n", 32'(rb_n), 32'd1);
        chk("R9 reset io_oe", 32'(io_oe), 32'd0);
        status(v);
        chk("R6 reset status", 32'(v), 32'hC0);
        chk("R9 io_oe during read", 32'(oe_seen), 32'd1);

        // program page 2: cols 3..6, then move to col 10
        cmd(8'h80); addr5(3, 2);
        for (int i = 0; i < 4; i++) begin
            dat(8'(i * 37 + 5));
            mdl[2][3 + i] = mdl[2][3 + i] & 8'(i * 37 + 5);
        end
        cmd(8'h85); adr(8'd10); adr(8'h00);
        dat(8'h5A); mdl[2][10] = mdl[2][10] & 8'h5A;
        dat(8'hC3); mdl[2][11] = mdl[2][11] & 8'hC3;
        go(8'h10, n);
        chk("R5 program busy length", 32'(n), 32'(PGC));
        status(v);
        chk("R5 program status", 32'(v), 32'hC0);

        // read sweep of every page
        for (int p = 0; p < PAGES; p++) begin
            cmd(8'h00); addr5(0, p);
            go(8'h30, n);
            chk("R1 read busy length", 32'(n), 32'(RDC));
            for (int c = 0; c < COLS; c++) begin
                rd(v);
                chk("R1 R3 page byte", 32'(v), 32'(mdl[p][c]));
            end
            rd(v);
            chk("R2 past last column", 32'(v), 32'(mdl[p][COLS-1]));
        end

        // read from a middle column
        cmd(8'h00); addr5(4, 2);
        go(8'h30, n);
        for (int c = 4; c < 8; c++) begin
            rd(v);
            chk("R2 column start", 32'(v), 32'(mdl[2][c]));
        end

        // ask for a 1 over a cleared bit
        cmd(8'h80); addr5(3, 2); dat(8'hFF);
        go(8'h10, n);
        status(v);
        chk("R5 fail bit", 32'(v), 32'hC1);
        cmd(8'h00); addr5(3, 2); go(8'h30, n);
        rd(v);
        chk("R5 cell not raised", 32'(v), 32'(mdl[2][3]));

        // reset command clears status
        cmd(8'hFF);
        status(v);
        chk("R10 status after reset cmd", 32'(v), 32'hC0);

        // lone confirm
        go(8'h10, n);
        chk("R4 lone confirm no busy", 32'(n), 32'd0);
        cmd(8'h80); addr5(0, 1);
        go(8'h10, n);
        chk("R4 confirm without data", 32'(n), 32'd0);

        // commands during busy
        cmd(8'h00); addr5(0, 2);
        cmd(8'h30);
        cmd(8'h80);
        dat(8'h00);
        status(v);
        chk("R6 status while busy", 32'(v), 32'h80);
        wait_ready();
        rd(v);
        chk("R7 status persists", 32'(v), 32'hC0);
        dat(8'h00);
        go(8'h10, n);
        chk("R6 load ignored while busy", 32'(n), 32'd0);
        cmd(8'h00); addr5(0, 2); go(8'h30, n);
        rd(v);
        chk("R7 leave status mode", 32'(v), 32'(mdl[2][0]));

        // abort during program
        cmd(8'h80); addr5(0, 3); dat(8'hAA); dat(8'hBB);
        cmd(8'h10);
        chk("R10 busy before abort", 32'(rb_n), 32'd0);
        cmd(8'hFF);
        chk("R10 ready after abort", 32'(rb_n), 32'd1);
        rd(v);
        chk("R10 column rewound", 32'(v), 32'hAA);
        rd(v);
        chk("R10 buffer kept", 32'(v), 32'hBB);

        // chip select high hides strobes
        ce_n = 1'b1;
        cmd(8'h70);
        ce_n = 1'b0;
        rd(v);
        chk("R9 ce_n high ignored", 32'(v), 32'hFF);

        // write protect
        wp_n = 1'b0;
        cmd(8'h80); addr5(0, 1); dat(8'h00);
        go(8'h10, n);
        chk("R11 protected no busy", 32'(n), 32'd0);
        status(v);
        chk("R11 protected status", 32'(v), 32'h41);
        wp_n = 1'b1;
        cmd(8'h00); addr5(0, 1); go(8'h30, n);
        rd(v);
        chk("R11 array unchanged", 32'(v), 32'(mdl[1][0]));

        // partial program cap on page 0
        for (int k = 0; k < NOPM; k++) begin
            cmd(8'h80); addr5(k, 0); dat(8'(8'h0F ^ k));
            mdl[0][k] = mdl[0][k] & 8'(8'h0F ^ k);
            go(8'h10, n);
            chk("R8 program within cap", 32'(n), 32'(PGC));
        end
        cmd(8'h80); addr5(NOPM, 0); dat(8'h00);
        go(8'h10, n);
        chk("R8 capped no busy", 32'(n), 32'd0);
        status(v);
        chk("R8 violation status", 32'(v), 32'hC3);
        cmd(8'h00); addr5(0, 0); go(8'h30, n);
        for (int c = 0; c < COLS; c++) begin
            rd(v);
            chk("R8 page after cap", 32'(v), 32'(mdl[0][c]));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule